// File: doc/BRIEF.md
# SPI paged register access sequencer

This block lets on-chip logic read or write one register of a peripheral whose register space is split into pages and reached over a four-wire SPI link. A local request carries a page number, an 8-bit register offset, a direction, a byte count of 1, 2, 4, 6 or 8, and up to eight bytes of write data. The engine then runs the whole exchange by itself and ends it with a one-cycle done or error pulse. Read results are returned on a 64-bit port.

Each access is a fixed series of SPI frames. First the engine polls the peripheral's status until it is no longer busy. Next it writes the page number into the page-select register. For a write it then sends the data frame. For a read it sends a throw-away one-byte read of the target offset, polls status until the read-acknowledge flag appears, and fetches the result through a fixed data window. The engine contains its own bit shifter and chip-select framing. It also has a retry timer whose period is a parameter; it is sized for one millisecond at the system clock rate.

Top module: `spi_paged_xfer`

## Requirements
- R1: Every frame starts with a command byte, 0x60 for a read or 0x61 for a write, followed by the register offset byte. Write data bytes follow least significant first.
- R2: The link uses SPI mode 0, MSB first. sclk_o is low whenever cs_no is high, and mosi_o changes only while sclk_o is low. cs_no stays low for one whole frame, goes high between frames, and every frame carries a whole number of bytes.
- R3: Before each access the engine reads status offset 0xFE, where bit 7 is busy. It makes up to MAX_TRIES reads and waits at least WAIT_CYCLES clocks between them. If bit 7 is still set on the last try, it pulses err_o and sends no further frames.
- R4: Once status is idle, the engine sends a three-byte write frame to offset 0xFF whose data byte is the request's page.
- R5: A write sends one frame of 2 + length bytes; for length 6 that is exactly six data bytes. done_o follows when the frame ends.
- R6: A read sends a one-byte read of the target offset and discards it. It then polls 0xFE for bit 5 (read-acknowledge) with the same retry limit and wait. If the flag never appears, it pulses err_o.
- R7: The read data comes from a read frame at offset 0xF0 of 2 + length bytes. The received bytes are placed little-endian on rdata_o, and the bytes above the length read as zero. rdata_o is changed only by a successful read.
- R8: req_ready_o is high only when the engine is idle, and it drops in the cycle after a request is accepted. Each accepted request ends with exactly one single-cycle pulse of either done_o or err_o, never both.
- R9: After reset: cs_no high, sclk_o low, req_ready_o high, done_o and err_o low, rdata_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_page_i | input | 8 | Page number |
| req_reg_i | input | 8 | Register offset within the page |
| req_len_i | input | 4 | Byte count: 1, 2, 4, 6 or 8 |
| req_wdata_i | input | 64 | Write data, byte 0 sent first |
| done_o | output | 1 | Single-cycle pulse, access complete |
| err_o | output | 1 | Single-cycle pulse, retry limit reached |
| rdata_o | output | 64 | Data of the last successful read |
| cs_no | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to peripheral |
| miso_i | input | 1 | SPI data from peripheral |

## Verification
The checker assumes that an accepted request always carries a legal byte count (1, 2, 4, 6 or 8). It also assumes that miso_i changes only while sclk_o is low, since the engine samples it on the rising edge. The bench's peripheral model drives miso on falling clock edges only, and every vector in the table uses a legal length. Request fields are sampled only in the accepting cycle, so the bench holds them for just that cycle.

// File: rtl/spi_pxfer_pkg.sv
package spi_pxfer_pkg;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * 8;

  localparam logic [7:0] CMD_BASE   = 8'h60;
  localparam logic [7:0] OFF_STATUS = 8'hFE;
  localparam logic [7:0] OFF_PAGE   = 8'hFF;
  localparam logic [7:0] OFF_WINDOW = 8'hF0;
  localparam int BUSY_BIT = 7;
  localparam int RACK_BIT = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BUSY_POLL, ST_BUSY_WAIT, ST_PAGE,
    ST_ACCESS, ST_ACK_POLL, ST_ACK_WAIT, ST_FETCH
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [7:0]        off;
    logic [3:0]        nbytes;
    logic [DATA_W-1:0] wdata;
  } frame_t;
endpackage

// File: rtl/spi_bit_shift.sv
module spi_bit_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        div_q    <= '0;
        bit_q    <= '0;
        sclk_o   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sclk_o) begin
            sclk_o <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_o <= 1'b0;
            tx_q   <= {tx_q[6:0], 1'b0};
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_o   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_pxfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  frame_t            frame_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              kick_o,
  output logic [7:0]        tx_byte_o,
  output logic              cs_no,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  frame_t            fr_q;
  logic              busy_q;
  logic [3:0]        idx_q;
  logic [3:0]        last_idx;
  logic [2:0]        bsel;
  logic [DATA_W-1:0] rdata_q;

  assign last_idx = fr_q.nbytes + 4'd1;
  assign bsel     = 3'(idx_q - 4'd2);

  always_comb begin
    if (idx_q == 4'd0)      tx_byte_o = CMD_BASE | {7'b0, fr_q.wr};
    else if (idx_q == 4'd1) tx_byte_o = fr_q.off;
    else if (fr_q.wr)       tx_byte_o = fr_q.wdata[{bsel, 3'b000} +: 8];
    else                    tx_byte_o = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q    <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      rdata_q <= '0;
      kick_o  <= 1'b0;
      cs_no   <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      kick_o <= 1'b0;
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        fr_q    <= frame_i;
        busy_q  <= 1'b1;
        idx_q   <= '0;
        rdata_q <= '0;
        cs_no   <= 1'b0;
        kick_o  <= 1'b1;
      end else if (busy_q && sh_done_i) begin
        if (idx_q >= 4'd2) rdata_q[{bsel, 3'b000} +: 8] <= sh_rx_i;
        if (idx_q == last_idx) begin
          busy_q <= 1'b0;
          cs_no  <= 1'b1;
          done_o <= 1'b1;
        end else begin
          idx_q  <= idx_q + 4'd1;
          kick_o <= 1'b1;
        end
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/retry_wait.sv
module retry_wait #(
  parameter int WAIT_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= CW'(WAIT_CYCLES - 1);
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q    <= 1'b0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_paged_xfer.sv
module spi_paged_xfer
  import spi_pxfer_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int WAIT_CYCLES = 100000,
  parameter int MAX_TRIES   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [7:0]        req_page_i,
  input  logic [7:0]        req_reg_i,
  input  logic [3:0]        req_len_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);
  localparam frame_t STATUS_RD = '{wr: 1'b0, off: OFF_STATUS, nbytes: 4'd1, wdata: '0};

  seq_state_e        st_q;
  frame_t            fr_q;
  logic              fr_start_q, tmr_start_q;
  logic [TW-1:0]     tries_q;
  logic              wr_q;
  logic [7:0]        page_q, reg_q;
  logic [3:0]        len_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic              fr_done, tmr_expire, kick, sh_done;
  logic [7:0]        tx_byte, sh_rx;
  logic [DATA_W-1:0] fr_rdata;
  logic              last_try;

  assign last_try = (tries_q == LAST_TRY);

  function automatic frame_t mk_frame(input logic wr, input logic [7:0] off,
                                      input logic [3:0] n, input logic [DATA_W-1:0] d);
    frame_t f;
    f.wr     = wr;
    f.off    = off;
    f.nbytes = n;
    f.wdata  = d;
    return f;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      fr_q        <= '0;
      fr_start_q  <= 1'b0;
      tmr_start_q <= 1'b0;
      tries_q     <= '0;
      wr_q        <= 1'b0;
      page_q      <= '0;
      reg_q       <= '0;
      len_q       <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      fr_start_q  <= 1'b0;
      tmr_start_q <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q       <= req_write_i;
          page_q     <= req_page_i;
          reg_q      <= req_reg_i;
          len_q      <= req_len_i;
          wdata_q    <= req_wdata_i;
          tries_q    <= '0;
          fr_q       <= STATUS_RD;
          fr_start_q <= 1'b1;
          st_q       <= ST_BUSY_POLL;
        end
        ST_BUSY_POLL: if (fr_done) begin
          if (!fr_rdata[BUSY_BIT]) begin
            fr_q       <= mk_frame(1'b1, OFF_PAGE, 4'd1, {{(DATA_W-8){1'b0}}, page_q});
            fr_start_q <= 1'b1;
            st_q       <= ST_PAGE;
          end else if (last_try) begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            tries_q     <= tries_q + TW'(1);
            tmr_start_q <= 1'b1;
            st_q        <= ST_BUSY_WAIT;
          end
        end
        ST_BUSY_WAIT: if (tmr_expire) begin
          fr_q       <= STATUS_RD;
          fr_start_q <= 1'b1;
          st_q       <= ST_BUSY_POLL;
        end
        ST_PAGE: if (fr_done) begin
          fr_q       <= wr_q ? mk_frame(1'b1, reg_q, len_q, wdata_q)
                             : mk_frame(1'b0, reg_q, 4'd1, '0);
          fr_start_q <= 1'b1;
          st_q       <= ST_ACCESS;
        end
        ST_ACCESS: if (fr_done) begin
          if (wr_q) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            tries_q    <= '0;
            fr_q       <= STATUS_RD;
            fr_start_q <= 1'b1;
            st_q       <= ST_ACK_POLL;
          end
        end
        ST_ACK_POLL: if (fr_done) begin
          if (fr_rdata[RACK_BIT]) begin
            fr_q       <= mk_frame(1'b0, OFF_WINDOW, len_q, '0);
            fr_start_q <= 1'b1;
            st_q       <= ST_FETCH;
          end else if (last_try) begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            tries_q     <= tries_q + TW'(1);
            tmr_start_q <= 1'b1;
            st_q        <= ST_ACK_WAIT;
          end
        end
        ST_ACK_WAIT: if (tmr_expire) begin
          fr_q       <= STATUS_RD;
          fr_start_q <= 1'b1;
          st_q       <= ST_ACK_POLL;
        end
        ST_FETCH: if (fr_done) begin
          rdata_q <= fr_rdata;
          done_o  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rdata_o     = rdata_q;

  spi_frame_ctl u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (fr_start_q),
    .frame_i   (fr_q),
    .sh_done_i (sh_done),
    .sh_rx_i   (sh_rx),
    .kick_o    (kick),
    .tx_byte_o (tx_byte),
    .cs_no     (cs_no),
    .done_o    (fr_done),
    .rdata_o   (fr_rdata)
  );

  spi_bit_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (kick),
    .tx_i    (tx_byte),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  retry_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start_q),
    .expire_o (tmr_expire)
  );
endmodule

// File: rtl/spi_paged_xfer_chk.sv
module spi_paged_xfer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [3:0] req_len_i,
  input logic       done_o,
  input logic       err_o,
  input logic       cs_no,
  input logic       sclk_o,
  input logic       mosi_o
);
  logic       cs_q, sclk_q;
  logic [6:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      cs_q   <= cs_no;
      sclk_q <= sclk_o;
      if (cs_q && !cs_no)       rise_cnt <= '0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 7'd1;
    end
  end

  assert_idle_clock_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_mosi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  assert_idle_no_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);

  assert_frame_bytes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !cs_q) |-> (rise_cnt[2:0] == 3'd0 && rise_cnt >= 7'd24 && rise_cnt <= 7'd80));

  assert_legal_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (req_len_i inside {4'd1, 4'd2, 4'd4, 4'd6, 4'd8}));

  assert_pulse_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind spi_paged_xfer spi_paged_xfer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_len_i   (req_len_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o)
);

// File: tb/tb_spi_paged_xfer.sv
`timescale 1ns/1ps
module tb_spi_paged_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int WAIT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_page = '0, req_reg = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, done, err, cs_n, sclk, mosi;
  logic        miso = 1'b0;
  logic [63:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_paged_xfer #(.CLK_DIV(DIV), .WAIT_CYCLES(WAIT), .MAX_TRIES(10)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_page_i(req_page), .req_reg_i(req_reg),
    .req_len_i(req_len), .req_wdata_i(req_wdata), .done_o(done), .err_o(err),
    .rdata_o(rdata), .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  logic [63:0] mem [int];
  int          busy_left, rack_left, rack_cfg, frames, bitc, bytec;
  int          last_nbytes, last_partial;
  bit          rack_pending;
  logic [7:0]  sh_in, ob, cmd_b, off_b, last_cmd, last_off, page_sel;
  logic [63:0] wacc, rdbuf;

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; wacc = '0; ob = '0; miso = 1'b0; frames++;
  end

  always @(posedge sclk) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        cmd_b = sh_in; ob = '0;
      end else if (bytec == 1) begin
        off_b = sh_in; ob = '0;
        if (cmd_b == 8'h60) begin
          if (off_b == 8'hFE) begin
            ob = {busy_left > 0, 1'b0, rack_pending && rack_left == 0, 5'b0};
            if (busy_left > 0) busy_left--;
            else if (rack_pending && rack_left > 0) rack_left--;
          end else if (off_b == 8'hF0) begin
            ob = rdbuf[7:0];
          end else begin
            rdbuf = mem.exists(page_sel * 256 + off_b) ? mem[page_sel * 256 + off_b] : '0;
            rack_pending = 1'b1;
            rack_left = rack_cfg;
          end
        end
      end else begin
        if (cmd_b == 8'h61) wacc[8*(bytec-2) +: 8] = sh_in;
        else if (off_b == 8'hF0) ob = 8'(rdbuf >> (8*(bytec-1)));
        else ob = '0;
      end
      bytec++;
    end
  end

  always @(negedge sclk) if (!cs_n) miso = ob[7-bitc];

  always @(posedge cs_n) if (bytec >= 2) begin
    last_nbytes = bytec; last_partial = bitc; last_cmd = cmd_b; last_off = off_b;
    if (cmd_b == 8'h61) begin
      if (off_b == 8'hFF) page_sel = wacc[7:0];
      else mem[page_sel * 256 + off_b] = wacc;
    end else if (off_b == 8'hF0) rack_pending = 1'b0;
  end

  // ---------------- gap monitor ----------------
  bit in_req = 0;
  int gap, maxgap;
  always @(negedge clk) if (in_req) begin
    if (cs_n) gap++;
    else begin
      if (gap > maxgap) maxgap = gap;
      gap = 0;
    end
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic        wr;
    logic [7:0]  page;
    logic [7:0]  off;
    logic [3:0]  len;
    logic [63:0] data;
    logic [3:0]  busy_n;
    logic [3:0]  rack_n;
    logic        exp_err;
    logic [4:0]  exp_frames;
    logic [63:0] exp_rd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd3, 8'h10, 4'd4, 64'h1122334455667788, 4'd0,  4'd0,  1'b0, 5'd3,  64'h0},
    '{1'b0, 8'd3, 8'h10, 4'd4, 64'h0,                4'd0,  4'd0,  1'b0, 5'd5,  64'h0000000055667788},
    '{1'b1, 8'd7, 8'h20, 4'd8, 64'hDEADBEEFCAFEF00D, 4'd2,  4'd0,  1'b0, 5'd5,  64'h0},
    '{1'b0, 8'd7, 8'h20, 4'd8, 64'h0,                4'd0,  4'd3,  1'b0, 5'd8,  64'hDEADBEEFCAFEF00D},
    '{1'b1, 8'd7, 8'h28, 4'd6, 64'hAABBCCDDEEFF0011, 4'd0,  4'd0,  1'b0, 5'd3,  64'h0},
    '{1'b0, 8'd7, 8'h28, 4'd6, 64'h0,                4'd0,  4'd0,  1'b0, 5'd5,  64'h0000CCDDEEFF0011},
    '{1'b1, 8'd3, 8'h10, 4'd1, 64'h0123456789ABCD99, 4'd0,  4'd0,  1'b0, 5'd3,  64'h0},
    '{1'b1, 8'd4, 8'h10, 4'd2, 64'h000000000000BEEF, 4'd0,  4'd0,  1'b0, 5'd3,  64'h0},
    '{1'b0, 8'd3, 8'h10, 4'd2, 64'h0,                4'd0,  4'd0,  1'b0, 5'd5,  64'h0000000000000099},
    '{1'b0, 8'd4, 8'h10, 4'd2, 64'h0,                4'd0,  4'd0,  1'b0, 5'd5,  64'h000000000000BEEF},
    '{1'b1, 8'd5, 8'h01, 4'd2, 64'h0000000000001234, 4'd10, 4'd0,  1'b1, 5'd10, 64'h0},
    '{1'b1, 8'd5, 8'h01, 4'd2, 64'h0000000000001234, 4'd9,  4'd0,  1'b0, 5'd12, 64'h0},
    '{1'b0, 8'd5, 8'h01, 4'd2, 64'h0,                4'd0,  4'd10, 1'b1, 5'd13, 64'h0},
    '{1'b0, 8'd5, 8'h01, 4'd2, 64'h0,                4'd0,  4'd9,  1'b0, 5'd14, 64'h0000000000001234}
  };

  logic [63:0] hold_rd = '0;

  task automatic run_vec(input vec_t v);
    int n = 0;
    busy_left = v.busy_n; rack_cfg = v.rack_n; rack_pending = 0; rack_left = 0;
    frames = 0; gap = 0; maxgap = 0;
    @(negedge clk);
    req_write = v.wr; req_page = v.page; req_reg = v.off; req_len = v.len;
    req_wdata = v.data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; in_req = 1;
    chk(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'h0);
    while (!(done || err) && n < 20000) begin @(negedge clk); n++; end
    in_req = 0;
    chk(err == v.exp_err && done == !v.exp_err, v.exp_err ? "R3/R6 err pulse" : "R8 done pulse",
        {62'h0, done, err}, {62'h0, !v.exp_err, v.exp_err});
    chk(frames == int'(v.exp_frames), "R3/R6 frame count", 64'(frames), 64'(v.exp_frames));
    chk(last_partial == 0, "R2 whole bytes per frame", 64'(last_partial), 64'h0);
    if (v.exp_err) begin
      chk(last_cmd == 8'h60 && last_off == 8'hFE && last_nbytes == 3, "R3 last frame is status read",
          {40'h0, last_cmd, last_off, 8'(last_nbytes)}, {40'h0, 8'h60, 8'hFE, 8'h03});
    end else begin
      chk(last_nbytes == 2 + int'(v.len), v.wr ? "R5 write frame length" : "R7 fetch frame length",
          64'(last_nbytes), 64'(2 + v.len));
      chk(last_cmd == (v.wr ? 8'h61 : 8'h60) && last_off == (v.wr ? v.off : 8'hF0), "R1 command and offset",
          {48'h0, last_cmd, last_off}, {48'h0, (v.wr ? 8'h61 : 8'h60), (v.wr ? v.off : 8'hF0)});
      chk(page_sel == v.page, "R4 page select", 64'(page_sel), 64'(v.page));
      if (!v.wr) hold_rd = v.exp_rd;
    end
    chk(rdata == hold_rd, "R7 read data", rdata, hold_rd);
    if (v.busy_n != 0 || v.rack_n != 0)
      chk(maxgap >= WAIT, "R3 retry wait", 64'(maxgap), 64'(WAIT));
    else
      chk(maxgap < WAIT, "R3 no wait without retry", 64'(maxgap), 64'(WAIT));
    @(negedge clk);
    chk(!done && !err && req_ready, "R8 single pulse then idle",
        {61'h0, done, err, req_ready}, 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && cs_n && !sclk && !done && !err && rdata == '0, "R9 reset state",
        {58'h0, req_ready, cs_n, sclk, done, err, |rdata}, {58'h0, 6'b110000});
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // directed: idle link after traffic (R2)
    repeat (5) @(negedge clk);
    chk(cs_n && !sclk, "R2 idle link", {62'h0, cs_n, sclk}, 64'h2);

    // directed: reset in idle clears read data (R9)
    chk(rdata == 64'h1234, "R7 data held before reset", rdata, 64'h1234);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rdata == '0 && req_ready && cs_n && !sclk, "R9 reset clears state",
        rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule